// File: doc/BRIEF.md
# Front-End Configuration Serialiser

This block turns one configuration command for the front-end chips into a serial burst. A start pulse hands it a command/address word, a 12-bit data word and a 16-bit pulse-count word. It then produces a configuration clock at half the system clock rate, a load strobe that separates the two parts of the burst, and a serial data line. The command/address part comes first with the load strobe low. The data part follows with the load strobe high and carries only as many of the most significant data bits as the count asks for.

The low three bits of the count word give the command/address length in units of eight pulses. The upper thirteen bits give the data length in single pulses, limited to the width of the data word. When the command is a read and the return path is enabled, the block copies the front-end return line onto its return output. It samples that line with the system clock from a fixed cycle after the start, and stops a few cycles after the data part ends. The controller has four states. IDLE waits for a start. ADDR clocks out the command/address part. DATA clocks out the data part. TAIL holds the block busy for a fixed number of trailing cycles. The transitions are IDLE to ADDR, DATA or TAIL on start, picked by which counts are non-zero. ADDR goes to DATA, or to TAIL if the data count is zero, after its last pulse. DATA goes to TAIL after its last pulse. TAIL goes to IDLE when its count runs out.

Top module: `fe_cfg_port`

## Requirements
- R1: After reset and whenever the block is idle, cck, ld, dao, busy and ret_out are all 0.
- R2: The command/address part has cnt_cfg[2:0] times 8 pulses. Each pulse is one system cycle low and then one cycle high, and the first low cycle begins on the clock edge that takes the start pulse. ld is 0 throughout this part.
- R3: The data part follows at once with min(cnt_cfg[15:3], 12) pulses of the same shape. ld is 1 during these pulses and nowhere else. It rises on the edge that begins the first data low cycle.
- R4: dao changes only when cck falls or at the start edge. In the command/address part it carries cmd_addr most significant bit first, then 0 once all 16 bits have been sent.
- R5: In the data part, dao carries data_in from bit 11 downward, one bit per pulse. A 9-pulse data part sends bits 11 down to 3.
- R6: A data count above 12 is treated as 12.
- R7: busy rises on the edge that takes an idle start. It stays high for 2*A + 2*D + 4 cycles, where A and D are the two pulse counts. A start pulse seen while busy changes nothing.
- R8: With is_read and ret_en both 1 at the start, ret_out is loaded with ret_in on each edge from the 19th edge after the start edge to the last busy edge. Otherwise ret_out is 0.
- R9: A count word of zero produces no pulses and keeps busy high for 4 cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a command |
| is_read | input | 1 | Command is a read |
| ret_en | input | 1 | Return path enable |
| cmd_addr | input | 16 | Command/address word, sent MSB first |
| data_in | input | 12 | Data word, MSBs sent |
| cnt_cfg | input | 16 | Pulse counts: [2:0] address units of 8, [15:3] data pulses |
| ret_in | input | 1 | Serial return line from the front ends |
| cck | output | 1 | Configuration clock |
| ld | output | 1 | Load strobe, high in data part |
| dao | output | 1 | Serial configuration data |
| busy | output | 1 | Burst in progress |
| ret_out | output | 1 | Forwarded return data |

## Verification
Every output is registered. A start taken at edge 0 therefore shapes what the ports show after that edge. Cycle c of the burst, the interval after edge c, has cck high when c is odd and c < 2A+2D, ld high for 2A <= c < 2A+2D, and busy high for c < 2A+2D+4. ret_out in cycle c holds the ret_in value present just before edge c, for 19 <= c <= 2A+2D+4. The driver computes one expected record for each cycle from these formulas before it raises start. The monitor then pops and compares one record one nanosecond after each rising edge, so every comparison lands in the cycle for which its record was computed.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } fcp_state_e;
endpackage

// File: rtl/fe_cfg_ctrl.sv
module fe_cfg_ctrl
    import fe_cfg_pkg::*;
#(
    parameter int CA_W     = 16,
    parameter int DATA_W   = 12,
    parameter int CNT_W    = 16,
    parameter int CA_FIELD = 3,
    parameter int CA_SCALE = 8,
    parameter int TAIL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CA_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  cnt_cfg,
    output logic              cck,
    output logic              ld,
    output logic              dao,
    output logic              busy
);
    localparam int NA_MAX   = ((1 << CA_FIELD) - 1) * CA_SCALE;
    localparam int PC_MAX0  = (NA_MAX > DATA_W) ? NA_MAX : DATA_W;
    localparam int PC_MAX   = (PC_MAX0 > TAIL_CYC) ? PC_MAX0 : TAIL_CYC;
    localparam int PC_W     = $clog2(PC_MAX + 1);
    localparam int ND_RAW_W = CNT_W - CA_FIELD;
    localparam logic [PC_W-1:0] TAIL_LD = PC_W'(TAIL_CYC - 1);

    fcp_state_e state, nxt;
    logic              ph;
    logic [PC_W-1:0]   pcnt;
    logic [PC_W-1:0]   nd_q;
    logic [CA_W-1:0]   ca_sh;
    logic [DATA_W-1:0] d_sh;
    logic              cck_q, ld_q, dao_q;

    logic [PC_W-1:0]     na_w;
    logic [PC_W-1:0]     nd_w;
    logic [ND_RAW_W-1:0] nd_raw;

    always_comb begin
        na_w   = PC_W'(cnt_cfg[CA_FIELD-1:0]) * PC_W'(CA_SCALE);
        nd_raw = cnt_cfg[CNT_W-1:CA_FIELD];
        nd_w   = (nd_raw > ND_RAW_W'(DATA_W)) ? PC_W'(DATA_W) : PC_W'(nd_raw);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) begin
                if (na_w != '0)      nxt = ST_ADDR;
                else if (nd_w != '0) nxt = ST_DATA;
                else                 nxt = ST_TAIL;
            end
            ST_ADDR: if (ph && pcnt == PC_W'(1))
                nxt = (nd_q != '0) ? ST_DATA : ST_TAIL;
            ST_DATA: if (ph && pcnt == PC_W'(1))
                nxt = ST_TAIL;
            ST_TAIL: if (pcnt == '0)
                nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= 1'b0;
            pcnt  <= '0;
            nd_q  <= '0;
            ca_sh <= '0;
            d_sh  <= '0;
            cck_q <= 1'b0;
            ld_q  <= 1'b0;
            dao_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    nd_q  <= nd_w;
                    ca_sh <= cmd_addr << 1;
                    d_sh  <= data_in;
                    ph    <= 1'b0;
                    cck_q <= 1'b0;
                    if (nxt == ST_ADDR) begin
                        pcnt  <= na_w;
                        ld_q  <= 1'b0;
                        dao_q <= cmd_addr[CA_W-1];
                    end else if (nxt == ST_DATA) begin
                        pcnt  <= nd_w;
                        ld_q  <= 1'b1;
                        dao_q <= data_in[DATA_W-1];
                        d_sh  <= data_in << 1;
                    end else begin
                        pcnt  <= TAIL_LD;
                        ld_q  <= 1'b0;
                        dao_q <= 1'b0;
                    end
                end
                ST_ADDR, ST_DATA: begin
                    if (!ph) begin
                        ph    <= 1'b1;
                        cck_q <= 1'b1;
                    end else begin
                        ph    <= 1'b0;
                        cck_q <= 1'b0;
                        if (nxt == state) begin
                            pcnt <= pcnt - 1'b1;
                            if (state == ST_ADDR) begin
                                dao_q <= ca_sh[CA_W-1];
                                ca_sh <= ca_sh << 1;
                            end else begin
                                dao_q <= d_sh[DATA_W-1];
                                d_sh  <= d_sh << 1;
                            end
                        end else if (nxt == ST_DATA) begin
                            pcnt  <= nd_q;
                            ld_q  <= 1'b1;
                            dao_q <= d_sh[DATA_W-1];
                            d_sh  <= d_sh << 1;
                        end else begin
                            pcnt  <= TAIL_LD;
                            ld_q  <= 1'b0;
                            dao_q <= 1'b0;
                        end
                    end
                end
                ST_TAIL: if (pcnt != '0) pcnt <= pcnt - 1'b1;
                default: ;
            endcase
        end
    end

    assign cck  = cck_q;
    assign ld   = ld_q;
    assign dao  = dao_q;
    assign busy = (state != ST_IDLE);

    // R2: no configuration clock outside a pulse phase
    p_cck_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_TAIL) |-> !cck_q);
    // R2: a high half lasts exactly one cycle
    p_cck_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cck_q |=> !cck_q);
    // R3: load strobe only during the data part
    p_ld_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |-> (state == ST_DATA));
    // R4: serial data holds while the clock is high
    p_dao_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cck_q |-> $stable(dao_q));
    // R7: an idle start always begins a burst
    p_busy_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> busy);

    initial begin
        if (TAIL_CYC < 1) $error("TAIL_CYC must be at least 1");
    end
endmodule

// File: rtl/fe_cfg_ret.sv
module fe_cfg_ret #(
    parameter int CYC_W     = 8,
    parameter int RET_START = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic rd_req,
    input  logic busy,
    input  logic ret_in,
    output logic ret_out
);
    logic [CYC_W-1:0] cyc;
    logic             fwd_q;
    logic             ret_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc   <= '0;
            fwd_q <= 1'b0;
            ret_q <= 1'b0;
        end else begin
            if (accept) begin
                cyc   <= CYC_W'(1);
                fwd_q <= rd_req;
            end else if (busy && cyc != '1) begin
                cyc <= cyc + 1'b1;
            end
            ret_q <= (busy && fwd_q && cyc >= CYC_W'(RET_START)) ? ret_in : 1'b0;
        end
    end

    assign ret_out = ret_q;

    // R8: nothing forwarded once the controller has been idle for a cycle
    p_ret_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !ret_q);
endmodule

// File: rtl/fe_cfg_port.sv
module fe_cfg_port #(
    parameter int CA_W      = 16,
    parameter int DATA_W    = 12,
    parameter int CNT_W     = 16,
    parameter int CA_FIELD  = 3,
    parameter int CA_SCALE  = 8,
    parameter int TAIL_CYC  = 4,
    parameter int RET_START = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic              ret_en,
    input  logic [CA_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  cnt_cfg,
    input  logic              ret_in,
    output logic              cck,
    output logic              ld,
    output logic              dao,
    output logic              busy,
    output logic              ret_out
);
    localparam int NA_MAX  = ((1 << CA_FIELD) - 1) * CA_SCALE;
    localparam int BURST   = 2 * NA_MAX + 2 * DATA_W + TAIL_CYC + 1;
    localparam int CYC_W0  = $clog2(BURST + 1);
    localparam int CYC_W1  = $clog2(RET_START + 1);
    localparam int CYC_W   = (CYC_W0 > CYC_W1) ? CYC_W0 : CYC_W1;

    logic accept;
    assign accept = start && !busy;

    fe_cfg_ctrl #(
        .CA_W(CA_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .CA_FIELD(CA_FIELD), .CA_SCALE(CA_SCALE), .TAIL_CYC(TAIL_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_addr(cmd_addr), .data_in(data_in), .cnt_cfg(cnt_cfg),
        .cck(cck), .ld(ld), .dao(dao), .busy(busy)
    );

    fe_cfg_ret #(
        .CYC_W(CYC_W), .RET_START(RET_START)
    ) u_ret (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .rd_req(is_read && ret_en), .busy(busy),
        .ret_in(ret_in), .ret_out(ret_out)
    );
endmodule

// File: tb/sim_fe_cfg_port.sv
module sim_fe_cfg_port;
    localparam int TAIL = 4;
    localparam int RSTART = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, is_read = 1'b0, ret_en = 1'b0, ret_in = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [11:0] data_in = '0;
    logic [15:0] cnt_cfg = '0;
    logic cck, ld, dao, busy, ret_out;

    always #2 clk = ~clk;

    fe_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .ret_en(ret_en), .cmd_addr(cmd_addr), .data_in(data_in),
        .cnt_cfg(cnt_cfg), .ret_in(ret_in), .cck(cck), .ld(ld),
        .dao(dao), .busy(busy), .ret_out(ret_out)
    );

    typedef struct {
        logic cck, ld, dao, busy, ret;
        bit   in_data;
        int   cyc;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    string label = "reset";
    bit done = 1'b0;

    function automatic logic pat(int c, int seed);
        return logic'(((c * 3) ^ (c >> 1) ^ seed) & 1);
    endfunction

    task automatic chk(string tag, logic act, logic exp, int c);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d: actual=%b expected=%b", tag, label, c, act, exp);
        end
    endtask

    // monitor: one record per cycle, sampled 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R2 cck", cck, e.cck, e.cyc);
                chk("R3 ld", ld, e.ld, e.cyc);
                chk(e.in_data ? "R5 dao" : "R4 dao", dao, e.dao, e.cyc);
                chk("R7 busy", busy, e.busy, e.cyc);
                chk("R8 ret_out", ret_out, e.ret, e.cyc);
            end
        end
    end

    // driver: computes the expected burst, then runs the stimulus
    task automatic do_cmd(string lbl, logic rd, logic en, logic [15:0] ca,
                          logic [11:0] dat, logic [15:0] cnt, int seed, int xs);
        int na, nd, fin;
        @(negedge clk);
        label = lbl;
        na = int'(cnt[2:0]) * 8;
        nd = int'(cnt[15:3]);
        if (nd > 12) nd = 12;                   // R6 clamp
        fin = 2 * na + 2 * nd + TAIL;           // R7 busy length
        for (int c = 0; c <= fin + 1; c++) begin
            exp_t e;
            e.cyc = c;
            e.busy = (c < fin);
            e.cck = (c < 2 * na + 2 * nd) && (c % 2 == 1);
            e.ld = (c >= 2 * na) && (c < 2 * na + 2 * nd);
            e.in_data = e.ld;
            if (c < 2 * na) begin
                e.dao = (c / 2 < 16) ? ca[15 - c / 2] : 1'b0;
            end else if (c < 2 * na + 2 * nd) begin
                e.dao = dat[11 - (c - 2 * na) / 2];
            end else begin
                e.dao = 1'b0;
            end
            e.ret = (rd && en && c >= RSTART && c <= fin) ? pat(c, seed) : 1'b0;
            q.push_back(e);
        end
        start = 1'b1; is_read = rd; ret_en = en;
        cmd_addr = ca; data_in = dat; cnt_cfg = cnt;
        ret_in = pat(0, seed);
        for (int c = 1; c <= fin + 1; c++) begin
            @(negedge clk);
            start = (c == xs);
            if (c == xs) begin
                // R7: a start while busy must leave the burst untouched
                cmd_addr = ~ca; data_in = ~dat; cnt_cfg = 16'h0003;
                is_read = ~rd; ret_en = 1'b1;
            end
            ret_in = pat(c, seed);
        end
        start = 1'b0;
    endtask

    // R1: idle cycles with no start
    task automatic idle_gap(int n);
        @(negedge clk);
        label = "R1 idle";
        for (int c = 0; c < n; c++) begin
            exp_t e;
            e.cyc = c; e.cck = 0; e.ld = 0; e.dao = 0; e.busy = 0; e.ret = 0; e.in_data = 0;
            q.push_back(e);
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        label = "R1 reset";
        chk("R1 cck", cck, 1'b0, 0);
        chk("R1 ld", ld, 1'b0, 0);
        chk("R1 dao", dao, 1'b0, 0);
        chk("R1 busy", busy, 1'b0, 0);
        chk("R1 ret_out", ret_out, 1'b0, 0);
        rst_n = 1'b1;
        idle_gap(3);
        // R2 R3 R5: 8 address pulses then one data pulse
        do_cmd("R2 count 0x0009", 1'b0, 1'b0, 16'hB5C3, 12'h855, 16'h0009, 0, -1);
        // R5 R8: 16 address pulses, 9 data bits (11..3), read forwarded
        do_cmd("R5 nine bits read", 1'b1, 1'b1, 16'h3A6F, 12'h855, 16'h004A, 1, -1);
        // R6: data count 20 clamped to 12, read with return disabled
        do_cmd("R6 clamp", 1'b1, 1'b0, 16'hFFFF, 12'hA5C, 16'h00A1, 0, -1);
        idle_gap(2);
        // R9: zero counts
        do_cmd("R9 zero count", 1'b1, 1'b1, 16'h1234, 12'hFFF, 16'h0000, 1, -1);
        // R3: data only, no address part, burst ends before return window
        do_cmd("R3 data only", 1'b1, 1'b1, 16'h8001, 12'h6B1, 16'h0028, 0, -1);
        // R7: second start while busy is ignored
        do_cmd("R7 busy start", 1'b0, 1'b0, 16'hC33C, 12'h3F0, 16'h0011, 0, 5);
        // R4 R8: longest burst, zeros after the 16 command bits
        do_cmd("R4 max burst read", 1'b1, 1'b1, 16'h9E27, 12'hD4B, 16'h0067, 1, -1);
        idle_gap(3);
        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule